// File: doc/BRIEF.md
# Accumulator Micro-Op ALU Engine

The engine sits behind a command processor and executes short arithmetic programs carried in the command stream. A program arrives as a packet: one header dword that announces its length, followed by a run of 32-bit micro-op dwords. Each micro-op does one of three things. It fills one of two source latches (A or B), or it combines the latches into a 64-bit accumulator that also sets zero and carry flags, or it writes a value back into a small file of 64-bit general-purpose registers.

Before a packet runs, the host preloads operands through a register write port. After the packet ends, the host collects results through a combinational read port. One micro-op is consumed per clock in which the stream presents a valid dword. A one-cycle done pulse marks the end of a packet. Malformed headers and micro-ops with unknown codes raise a sticky error flag.

Top module: `mop_alu_engine`

## Requirements
- R1: After synchronous active-low reset, every general register, both latches, the accumulator and both flags are zero, and err and done are low.
- R2: A header is a dword whose bits 31:23 equal 0x1a; its bits 7:0 hold L, and exactly L+1 micro-op dwords follow it (total packet length L+2). A dword offered while awaiting a header whose bits 31:23 differ from 0x1a is discarded and sets err.
- R3: A micro-op carries its operation code in bits 31:20, its first operand in bits 19:10 and its second operand in bits 9:0; micro-ops take effect one per accepted dword, in stream order.
- R4: LOAD (0x080) copies, and LOADINV (0x480) copies the bitwise complement of, the source named by operand 2 into the latch named by operand 1 (0x20 = A, 0x21 = B). Sources are R0–R4 (0x00–0x04), A, B, accumulator 0x31, zero flag 0x32 and carry flag 0x33.
- R5: LOAD0 (0x081) and LOAD1 (0x481) put the constant 0 or 1 into the latch named by operand 1; operand 2 is ignored and raises no error.
- R6: ADD (0x100) sets accumulator = A + B and carry = carry-out; SUB (0x101) sets accumulator = A − B (modulo 2^64) and carry = borrow (A < B unsigned). Both set zero = (accumulator == 0).
- R7: AND (0x102), OR (0x103) and XOR (0x104) put the bitwise result in the accumulator, clear carry and set zero = (accumulator == 0). ALU operations ignore both operand fields.
- R8: STORE (0x180) writes, and STOREINV (0x580) writes the complement of, the source named by operand 2 into register operand 1 (R0–R4). A flag used as a source reads as all-ones when set and as zero when clear.
- R9: An unknown operation code, an unknown source, or a destination of the wrong kind sets err, which then stays set until reset. Such a micro-op changes no register, latch, accumulator or flag, but it still counts toward the packet length.
- R10: done is high for exactly the one cycle after the edge that accepts a packet's last micro-op. The next dword is then taken as a header.
- R11: When wr_en is high, wr_data is written into register wr_addr at the clock edge. rd_data shows register rd_addr combinationally, and reads zero for addresses 5–7. If a micro-op store and a host write target the same register in one cycle, the store wins.
- R12: in_ready is high in every cycle. A cycle with in_valid low consumes nothing and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Stream dword valid |
| in_dword | input | 32 | Stream dword (header or micro-op) |
| in_ready | output | 1 | Engine accepts a dword this cycle |
| wr_en | input | 1 | Host register write enable |
| wr_addr | input | 3 | Host write register index |
| wr_data | input | 64 | Host write value |
| rd_addr | input | 3 | Host read register index |
| rd_data | output | 64 | Register value at rd_addr |
| done | output | 1 | One-cycle pulse after the last micro-op of a packet |
| err | output | 1 | Sticky error: bad header, bad code or bad operand |

## Verification
A wrong latch, accumulator or flag value has no port of its own. It becomes visible only when a later STORE copies it into a register, so each ALU case ends with stores of the accumulator, the carry flag and the zero flag, which are read back right after done. A wrong length counter shows up as done firing a cycle early or late relative to the final micro-op. It may also show as a following header being executed as a micro-op, which corrupts the next packet's results. A decode fault that lets an illegal micro-op through either leaves err low or overwrites a register that the bench expects to be unchanged.

// File: rtl/mop_pkg.sv
// Package: shared encodings for the micro-op ALU engine.
// Assumes the stream dword is 32 bits and the code fields are fixed by the
// command format; only the register count and data width are tunable.
package mop_pkg;
    localparam int WORD_W     = 32;
    localparam int OPC_W      = 12;
    localparam int OPD_W      = 10;
    localparam int HDR_OPC_LSB = 23;
    localparam int HDR_OPC_W  = WORD_W - HDR_OPC_LSB;
    localparam logic [HDR_OPC_W-1:0] HDR_OPC = 9'h1a;

    localparam logic [OPC_W-1:0] OPC_LOAD     = 12'h080;
    localparam logic [OPC_W-1:0] OPC_LOADINV  = 12'h480;
    localparam logic [OPC_W-1:0] OPC_LOAD0    = 12'h081;
    localparam logic [OPC_W-1:0] OPC_LOAD1    = 12'h481;
    localparam logic [OPC_W-1:0] OPC_ADD      = 12'h100;
    localparam logic [OPC_W-1:0] OPC_SUB      = 12'h101;
    localparam logic [OPC_W-1:0] OPC_AND      = 12'h102;
    localparam logic [OPC_W-1:0] OPC_OR       = 12'h103;
    localparam logic [OPC_W-1:0] OPC_XOR      = 12'h104;
    localparam logic [OPC_W-1:0] OPC_STORE    = 12'h180;
    localparam logic [OPC_W-1:0] OPC_STOREINV = 12'h580;

    localparam logic [OPD_W-1:0] OPD_LAT_A = 10'h020;
    localparam logic [OPD_W-1:0] OPD_LAT_B = 10'h021;
    localparam logic [OPD_W-1:0] OPD_ACC   = 10'h031;
    localparam logic [OPD_W-1:0] OPD_ZF    = 10'h032;
    localparam logic [OPD_W-1:0] OPD_CF    = 10'h033;

    typedef enum logic [2:0] {
        K_NONE,
        K_LOAD,
        K_CONST,
        K_ALU,
        K_STORE
    } uop_kind_e;

    typedef enum logic [2:0] {
        A_ADD,
        A_SUB,
        A_AND,
        A_OR,
        A_XOR
    } alu_fn_e;
endpackage

// File: rtl/mop_seq.sv
// Module: packet sequencer.
// Takes a header, loads the remaining micro-op count, then forwards each
// accepted dword as a micro-op until the count runs out, and pulses done.
// Assumes the stream may pause at any time; the engine never stalls.
module mop_seq
    import mop_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [HDR_OPC_W-1:0]  hdr_opc,
    input  logic [LEN_W-1:0]      hdr_len,
    output logic                  uop_fire,
    output logic                  hdr_err,
    output logic                  done
);
    typedef enum logic {S_HDR, S_RUN} seq_state_e;

    seq_state_e       state_q;
    logic [LEN_W-1:0] rem_q;
    logic             done_q;
    logic             hdr_ok;

    // Header opcode match.
    assign hdr_ok   = (hdr_opc == HDR_OPC);
    // Micro-op issue and header error strobes.
    assign uop_fire = in_valid && (state_q == S_RUN);
    assign hdr_err  = in_valid && (state_q == S_HDR) && !hdr_ok;
    assign done     = done_q;

    // State, remaining count and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_HDR;
            rem_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (in_valid) begin
                if (state_q == S_HDR) begin
                    if (hdr_ok) begin
                        state_q <= S_RUN;
                        rem_q   <= hdr_len;
                    end
                end else if (rem_q == '0) begin
                    state_q <= S_HDR;
                    done_q  <= 1'b1;
                end else begin
                    rem_q <= rem_q - 1'b1;
                end
            end
        end
    end

    // R2: the count drops by one per micro-op while more remain
    a_r2_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RUN && in_valid && rem_q != '0)
        |=> (state_q == S_RUN && rem_q == $past(rem_q) - 1'b1));

    // R2: a malformed header leaves the sequencer waiting for a header
    a_r2_bad_header_idle: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_err |=> (state_q == S_HDR));

    // R10: done never lasts two cycles
    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
endmodule

// File: rtl/mop_regfile.sv
// Module: general register file.
// NUM_GPR live 64-bit registers in a 2**ADDR_W slot space; unused slots
// read zero. A micro-op store has priority over a host write to the same
// register in the same cycle.
module mop_regfile #(
    parameter int NUM_GPR = 5,
    parameter int DATA_W  = 64,
    parameter int ADDR_W  = 3
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              host_we,
    input  logic [ADDR_W-1:0]                 host_addr,
    input  logic [DATA_W-1:0]                 host_data,
    input  logic                              st_en,
    input  logic [ADDR_W-1:0]                 st_addr,
    input  logic [DATA_W-1:0]                 st_data,
    output logic [(1<<ADDR_W)-1:0][DATA_W-1:0] regs
);
    localparam int SLOTS = 1 << ADDR_W;

    for (genvar gi = 0; gi < SLOTS; gi++) begin : g_slot
        if (gi < NUM_GPR) begin : g_live
            logic [DATA_W-1:0] val_q;
            // One register: store beats host write.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    val_q <= '0;
                end else if (st_en && st_addr == ADDR_W'(gi)) begin
                    val_q <= st_data;
                end else if (host_we && host_addr == ADDR_W'(gi)) begin
                    val_q <= host_data;
                end
            end
            assign regs[gi] = val_q;
        end else begin : g_empty
            assign regs[gi] = '0;
        end
    end

    // R8: a store lands in its destination at the next edge
    a_r8_store_lands: assert property (@(posedge clk) disable iff (!rst_n)
        st_en |=> (regs[$past(st_addr)] == $past(st_data)));
endmodule

// File: rtl/mop_exec.sv
// Module: micro-op decoder and accumulator datapath.
// Holds latches A and B, the accumulator and the zero/carry flags, decodes
// each fired micro-op and produces a register store request. An illegal
// micro-op raises op_err and leaves all state untouched.
module mop_exec
    import mop_pkg::*;
#(
    parameter int NUM_GPR = 5,
    parameter int DATA_W  = 64,
    parameter int ADDR_W  = 3
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               fire,
    input  logic [WORD_W-1:0]                  uop,
    input  logic [(1<<ADDR_W)-1:0][DATA_W-1:0] regs,
    output logic                               st_en,
    output logic [ADDR_W-1:0]                  st_addr,
    output logic [DATA_W-1:0]                  st_data,
    output logic                               op_err
);
    logic [OPC_W-1:0] opc;
    logic [OPD_W-1:0] opd1, opd2;
    logic [DATA_W-1:0] a_q, b_q, acc_q;
    logic              zf_q, cf_q;

    logic [DATA_W-1:0] src_val;
    logic              src_ok;
    logic              lat_ok, dst_ok;
    uop_kind_e         kind;
    alu_fn_e           fn;
    logic              inv, one, legal;
    logic [DATA_W:0]   alu_wide;
    logic [DATA_W-1:0] alu_res;
    logic              alu_cf;
    logic              alu_upd, is_logic;

    // Field split of the micro-op dword.
    assign opc  = uop[WORD_W-1 -: OPC_W];
    assign opd1 = uop[2*OPD_W-1 -: OPD_W];
    assign opd2 = uop[OPD_W-1:0];

    // Source operand lookup named by operand 2.
    always_comb begin
        src_ok  = 1'b1;
        src_val = '0;
        case (opd2)
            OPD_LAT_A: src_val = a_q;
            OPD_LAT_B: src_val = b_q;
            OPD_ACC:   src_val = acc_q;
            OPD_ZF:    src_val = {DATA_W{zf_q}};
            OPD_CF:    src_val = {DATA_W{cf_q}};
            default: begin
                if (opd2 < OPD_W'(NUM_GPR)) src_val = regs[opd2[ADDR_W-1:0]];
                else                        src_ok  = 1'b0;
            end
        endcase
    end

    // Destination checks for latches and registers.
    assign lat_ok = (opd1 == OPD_LAT_A) || (opd1 == OPD_LAT_B);
    assign dst_ok = (opd1 < OPD_W'(NUM_GPR));

    // Operation decode.
    always_comb begin
        kind = K_NONE;
        fn   = A_ADD;
        inv  = 1'b0;
        one  = 1'b0;
        case (opc)
            OPC_LOAD:     kind = K_LOAD;
            OPC_LOADINV:  begin kind = K_LOAD;  inv = 1'b1; end
            OPC_LOAD0:    kind = K_CONST;
            OPC_LOAD1:    begin kind = K_CONST; one = 1'b1; end
            OPC_ADD:      begin kind = K_ALU; fn = A_ADD; end
            OPC_SUB:      begin kind = K_ALU; fn = A_SUB; end
            OPC_AND:      begin kind = K_ALU; fn = A_AND; end
            OPC_OR:       begin kind = K_ALU; fn = A_OR;  end
            OPC_XOR:      begin kind = K_ALU; fn = A_XOR; end
            OPC_STORE:    kind = K_STORE;
            OPC_STOREINV: begin kind = K_STORE; inv = 1'b1; end
            default:      kind = K_NONE;
        endcase
    end

    // Legality of the decoded micro-op.
    always_comb begin
        case (kind)
            K_LOAD:  legal = lat_ok && src_ok;
            K_CONST: legal = lat_ok;
            K_ALU:   legal = 1'b1;
            K_STORE: legal = dst_ok && src_ok;
            default: legal = 1'b0;
        endcase
    end

    // Accumulator arithmetic and flag sources.
    always_comb begin
        alu_wide = '0;
        alu_cf   = 1'b0;
        case (fn)
            A_ADD: begin
                alu_wide = {1'b0, a_q} + {1'b0, b_q};
                alu_cf   = alu_wide[DATA_W];
            end
            A_SUB: begin
                alu_wide = {1'b0, a_q} - {1'b0, b_q};
                alu_cf   = alu_wide[DATA_W];
            end
            A_AND:   alu_wide = {1'b0, a_q & b_q};
            A_OR:    alu_wide = {1'b0, a_q | b_q};
            default: alu_wide = {1'b0, a_q ^ b_q};
        endcase
        alu_res = alu_wide[DATA_W-1:0];
    end

    assign is_logic = (fn == A_AND) || (fn == A_OR) || (fn == A_XOR);
    assign alu_upd  = fire && legal && (kind == K_ALU);
    assign op_err   = fire && !legal;

    // Store request toward the register file.
    assign st_en   = fire && legal && (kind == K_STORE);
    assign st_addr = opd1[ADDR_W-1:0];
    assign st_data = inv ? ~src_val : src_val;

    // Latches, accumulator and flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q   <= '0;
            b_q   <= '0;
            acc_q <= '0;
            zf_q  <= 1'b0;
            cf_q  <= 1'b0;
        end else if (fire && legal) begin
            if (kind == K_LOAD || kind == K_CONST) begin
                logic [DATA_W-1:0] lv;
                if (kind == K_CONST) lv = one ? DATA_W'(1) : '0;
                else                 lv = inv ? ~src_val : src_val;
                if (opd1 == OPD_LAT_A) a_q <= lv;
                else                   b_q <= lv;
            end else if (kind == K_ALU) begin
                acc_q <= alu_res;
                zf_q  <= (alu_res == '0);
                cf_q  <= alu_cf;
            end
        end
    end

    // R6: the zero flag matches the accumulator after an ALU operation
    a_r6_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
        alu_upd |=> (zf_q == (acc_q == '0)));

    // R7: logic operations leave carry clear
    a_r7_logic_clears_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_upd && is_logic) |=> !cf_q);

    // R9: an illegal micro-op leaves the datapath state unchanged
    a_r9_illegal_holds: assert property (@(posedge clk) disable iff (!rst_n)
        op_err |=> ($stable(a_q) && $stable(b_q) && $stable(acc_q)
                    && $stable(zf_q) && $stable(cf_q)));
endmodule

// File: rtl/mop_alu_engine.sv
// Module: top of the micro-op ALU engine.
// Joins the packet sequencer, the decoder/datapath and the register file,
// and keeps the sticky error flag. Assumes a 32-bit stream dword and a
// host that preloads and reads registers around packets.
module mop_alu_engine
    import mop_pkg::*;
#(
    parameter int NUM_GPR = 5,
    parameter int DATA_W  = 64,
    parameter int LEN_W   = 8,
    parameter int ADDR_W  = $clog2(NUM_GPR)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [31:0]       in_dword,
    output logic              in_ready,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              done,
    output logic              err
);
    logic                               uop_fire, hdr_err, op_err;
    logic                               st_en;
    logic [ADDR_W-1:0]                  st_addr;
    logic [DATA_W-1:0]                  st_data;
    logic [(1<<ADDR_W)-1:0][DATA_W-1:0] regs;
    logic                               err_q;

    // The engine executes one dword per cycle and never back-pressures.
    assign in_ready = 1'b1;

    mop_seq #(.LEN_W(LEN_W)) i_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .hdr_opc  (in_dword[WORD_W-1:HDR_OPC_LSB]),
        .hdr_len  (in_dword[LEN_W-1:0]),
        .uop_fire (uop_fire),
        .hdr_err  (hdr_err),
        .done     (done)
    );

    mop_exec #(.NUM_GPR(NUM_GPR), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_exec (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (uop_fire),
        .uop     (in_dword),
        .regs    (regs),
        .st_en   (st_en),
        .st_addr (st_addr),
        .st_data (st_data),
        .op_err  (op_err)
    );

    mop_regfile #(.NUM_GPR(NUM_GPR), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_we   (wr_en),
        .host_addr (wr_addr),
        .host_data (wr_data),
        .st_en     (st_en),
        .st_addr   (st_addr),
        .st_data   (st_data),
        .regs      (regs)
    );

    // Combinational host read.
    assign rd_data = regs[rd_addr];

    // Sticky error accumulation.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= err_q | hdr_err | op_err;
    end
    assign err = err_q;

    // R9: once set, err stays set until reset
    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);

    // R9: any detected fault is reflected on err at the next edge
    a_r9_err_raised: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_err || op_err) |=> err_q);
endmodule

// File: tb/test_mop_alu_engine.sv
module test_mop_alu_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_dword = '0;
    logic        in_ready;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [63:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [63:0] rd_data;
    logic        done;
    logic        err;

    int n_chk = 0;
    int n_bad = 0;

    mop_alu_engine i_mop_alu_engine (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dword(in_dword),
        .in_ready(in_ready), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .done(done), .err(err)
    );

    always #5 clk = ~clk;

    localparam logic [11:0] LD = 12'h080, LDI = 12'h480, LD0 = 12'h081, LD1 = 12'h481;
    localparam logic [11:0] ADD = 12'h100, SUB = 12'h101, AND_ = 12'h102, OR_ = 12'h103, XOR_ = 12'h104;
    localparam logic [11:0] ST = 12'h180, STI = 12'h580;
    localparam logic [9:0]  LA = 10'h20, LB = 10'h21, ACC = 10'h31, ZF = 10'h32, CF = 10'h33;

    localparam int NV = 8;
    localparam logic [63:0] VA [NV] = '{64'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'd10, 64'd3,
                                       64'hF0F0_F0F0_1234_5678, 64'h00FF_0000_0000_0001, 64'd5, 64'hDEAD_BEEF_0BAD_F00D};
    localparam logic [63:0] VB [NV] = '{64'd4, 64'd1, 64'd3, 64'd10,
                                       64'hFF00_FF00_FFFF_0000, 64'h0F00_0000_0000_0010, 64'd5, 64'hDEAD_BEEF_0BAD_F00D};
    localparam logic [11:0] VOP [NV] = '{ADD, ADD, SUB, SUB, AND_, OR_, SUB, XOR_};

    function automatic logic [31:0] uop(input logic [11:0] o, input logic [9:0] x, input logic [9:0] y);
        return {o, x, y};
    endfunction

    function automatic logic [31:0] hdr(input int n_ops);
        return (32'h1a << 23) | 32'(n_ops - 1);
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic put(input logic [31:0] d);
        in_valid = 1'b1;
        in_dword = d;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic stop_stream();
        in_valid = 1'b0;
        in_dword = '0;
    endtask

    task automatic host_wr(input logic [2:0] a, input logic [63:0] v);
        wr_en = 1'b1; wr_addr = a; wr_data = v;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic host_rd(input logic [2:0] a, output logic [63:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; in_valid = 1'b0; wr_en = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    function automatic void ref_alu(input logic [11:0] o, input logic [63:0] a, input logic [63:0] b,
                                    output logic [63:0] r, output logic c);
        logic [64:0] w;
        c = 1'b0;
        case (o)
            ADD:     begin w = {1'b0, a} + {1'b0, b}; r = w[63:0]; c = w[64]; end
            SUB:     begin r = a - b; c = (a < b); end
            AND_:    r = a & b;
            OR_:     r = a | b;
            default: r = a ^ b;
        endcase
    endfunction

    initial begin
        #(200000 * 10);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [63:0] v, er;
        logic        ec;
        @(negedge clk);
        do_reset();

        // R1: reset state at the ports
        for (int i = 0; i < 5; i++) begin
            host_rd(3'(i), v);
            chk($sformatf("R1 reg%0d after reset", i), v, 64'd0);
        end
        chk("R1 err after reset", {63'd0, err}, 64'd0);
        chk("R1 done after reset", {63'd0, done}, 64'd0);
        chk("R12 in_ready high", {63'd0, in_ready}, 64'd1);

        // R1: hidden accumulator, latch A and flags read zero after reset
        host_wr(3'd0, 64'h1234);
        host_wr(3'd1, 64'h5678);
        put(hdr(4));
        put(uop(ST, 10'd0, ACC));
        put(uop(ST, 10'd1, LA));
        put(uop(ST, 10'd2, ZF));
        put(uop(ST, 10'd3, CF));
        stop_stream();
        chk("R10 done after reset packet", {63'd0, done}, 64'd1);
        host_rd(3'd0, v); chk("R1 accumulator reset", v, 64'd0);
        host_rd(3'd1, v); chk("R1 latch A reset", v, 64'd0);
        host_rd(3'd2, v); chk("R1 zero flag reset", v, 64'd0);
        host_rd(3'd3, v); chk("R1 carry flag reset", v, 64'd0);
        @(negedge clk);
        chk("R10 done lasts one cycle", {63'd0, done}, 64'd0);

        // R6 R7 R8: table of ALU cases, each storing accumulator, carry, zero
        for (int k = 0; k < NV; k++) begin
            host_wr(3'd1, VA[k]);
            host_wr(3'd2, VB[k]);
            put(hdr(6));
            put(uop(LD, LA, 10'd1));
            put(uop(LD, LB, 10'd2));
            put(uop(VOP[k], 10'h3FF, 10'h3FF));
            put(uop(ST, 10'd3, ACC));
            put(uop(ST, 10'd4, CF));
            put(uop(ST, 10'd0, ZF));
            stop_stream();
            ref_alu(VOP[k], VA[k], VB[k], er, ec);
            chk($sformatf("R10 done vec%0d", k), {63'd0, done}, 64'd1);
            host_rd(3'd3, v);
            chk($sformatf("R6/R7 result vec%0d op %h", k, VOP[k]), v, er);
            host_rd(3'd4, v);
            chk($sformatf("R6/R7 carry vec%0d", k), v, {64{ec}});
            host_rd(3'd0, v);
            chk($sformatf("R8 zero flag vec%0d", k), v, {64{er == 64'd0}});
        end

        // R8 R4 R5: nonzero test of R0 via inverted zero flag
        for (int t = 0; t < 2; t++) begin
            host_wr(3'd0, (t == 0) ? 64'd5 : 64'd0);
            host_wr(3'd1, 64'd1);
            put(hdr(8));
            put(uop(LD, LA, 10'd0));
            put(uop(LD0, LB, 10'h3FF));
            put(uop(ADD, 10'd0, 10'd0));
            put(uop(STI, 10'd0, ZF));
            put(uop(LD, LA, 10'd0));
            put(uop(LD, LB, 10'd1));
            put(uop(AND_, 10'd0, 10'd0));
            put(uop(ST, 10'd0, ACC));
            stop_stream();
            host_rd(3'd0, v);
            chk($sformatf("R8 nonzero bool case%0d", t), v, (t == 0) ? 64'd1 : 64'd0);
        end

        // R4 R5: LOAD1, LOADINV and STOREINV of a latch
        host_wr(3'd1, 64'h0123_4567_89AB_CDEF);
        put(hdr(4));
        put(uop(LD1, LA, 10'h3FF));
        put(uop(LDI, LB, 10'd1));
        put(uop(ST, 10'd2, LA));
        put(uop(ST, 10'd3, LB));
        stop_stream();
        host_rd(3'd2, v); chk("R5 LOAD1 gives one", v, 64'd1);
        host_rd(3'd3, v); chk("R4 LOADINV complement", v, ~64'h0123_4567_89AB_CDEF);
        chk("R5 ignored operand raises no err", {63'd0, err}, 64'd0);
        put(hdr(1));
        put(uop(STI, 10'd4, LB));
        stop_stream();
        host_rd(3'd4, v); chk("R8 STOREINV of latch B", v, 64'h0123_4567_89AB_CDEF);

        // R12: stalls between micro-ops; R10 no early done
        host_wr(3'd1, 64'd100);
        put(hdr(2));
        stop_stream();
        @(negedge clk);
        chk("R10 no done after header", {63'd0, done}, 64'd0);
        put(uop(LD, LA, 10'd1));
        stop_stream();
        repeat (3) @(negedge clk);
        chk("R12 no done during stall", {63'd0, done}, 64'd0);
        chk("R12 in_ready during stall", {63'd0, in_ready}, 64'd1);
        put(uop(ST, 10'd2, LA));
        stop_stream();
        chk("R10 done after stalled packet", {63'd0, done}, 64'd1);
        host_rd(3'd2, v); chk("R3 stalled packet result", v, 64'd100);

        // R11: store beats host write; other register written by host
        put(hdr(1));
        wr_en = 1'b1; wr_addr = 3'd2; wr_data = 64'hDEAD;
        put(uop(ST, 10'd2, 10'd1));
        wr_en = 1'b0;
        stop_stream();
        host_rd(3'd2, v); chk("R11 store wins collision", v, 64'd100);
        host_rd(3'd6, v); chk("R11 out-of-range read zero", v, 64'd0);

        // R2: length field counts micro-ops; following dword is a header
        host_wr(3'd3, 64'd7);
        put(hdr(1));
        put(uop(ST, 10'd4, 10'd3));
        stop_stream();
        put(hdr(1));
        put(uop(ST, 10'd0, 10'd4));
        stop_stream();
        host_rd(3'd0, v); chk("R2 back-to-back packets", v, 64'd7);
        chk("R2 valid headers raise no err", {63'd0, err}, 64'd0);

        // R9: illegal micro-ops set err, change nothing, still count
        host_wr(3'd1, 64'h55);
        put(hdr(3));
        put(uop(12'h123, LA, 10'd0));
        put(uop(ST, 10'd1, 10'h025));
        put(uop(ST, 10'd7, ACC));
        stop_stream();
        chk("R9 done counts illegal ops", {63'd0, done}, 64'd1);
        chk("R9 err set", {63'd0, err}, 64'd1);
        host_rd(3'd1, v); chk("R9 register untouched", v, 64'h55);
        repeat (2) @(negedge clk);
        chk("R9 err sticky", {63'd0, err}, 64'd1);

        // R2: malformed header after reset is discarded
        do_reset();
        chk("R1 err cleared by reset", {63'd0, err}, 64'd0);
        host_wr(3'd1, 64'd77);
        put(32'h0000_0001);
        stop_stream();
        chk("R2 bad header sets err", {63'd0, err}, 64'd1);
        put(hdr(1));
        put(uop(ST, 10'd0, 10'd1));
        stop_stream();
        chk("R2 packet after bad header done", {63'd0, done}, 64'd1);
        host_rd(3'd0, v); chk("R2 packet after bad header", v, 64'd77);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule